// File: doc/BRIEF.md
# Pseudo-Random Sequenced Serial Address Register

This block holds the address for a parallel memory in a single shift-left register. It has two sources for the bit that enters at the least significant end. In external mode, a one-bit serial input provides it, so software can load a full address over WIDTH clocks, or move a short distance by shifting in only a few low bits. In sequence mode, the XOR of a fixed set of tap bits provides it. The register then steps through a maximal-length pseudo-random order, taking one clock for each new address. This lets a memory be streamed with one clock per word and still be reached at any address.

The serial input is a plain enabled stream and has no back-pressure. Every clock with `step_en` high consumes one bit (external mode) or one step (sequence mode). A clock with `step_en` low leaves the register unchanged. The register resets to the value 1. The all-zero value locks the sequence, so it is flagged as illegal while sequence mode is selected.

Top module: `lfsr_addr_reg`

## Requirements
- R1: The synchronous reset loads the address with 1, and `lockup` is low afterwards.
- R2: On every clock with `step_en` high, address bits move up by one position (bit i takes the old bit i-1) and the old top bit is dropped.
- R3: In sequence mode (`ext_mode`=0), the new bit 0 is the XOR of the tap bits. At the default width of 20, the taps are bits 19 and 16 (x^20 + x^17 + 1).
- R4: The sequence is maximal length. Starting from the seed 1, the address returns to 1 after exactly 2^WIDTH - 1 steps and not earlier. The bench checks this on a 16-bit instance, whose taps are bits 15, 13, 12 and 10.
- R5: In external mode (`ext_mode`=1), `ser_in` replaces the feedback bit. After WIDTH enabled shifts of a value, most significant bit first, the address equals that value.
- R6: A partial load of k bits from address A gives {A[WIDTH-1-k:0], the k shifted bits}.
- R7: With `step_en` low, the address holds its value, whatever `ext_mode` and `ser_in` do.
- R8: `lockup` is high exactly when the address is all zeros and `ext_mode` is 0. An all-zero address stays all zeros when it is stepped in sequence mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Shift/step enable |
| ext_mode | input | 1 | 1: serial input feeds bit 0; 0: tap feedback |
| ser_in | input | 1 | Serial address bit |
| addr | output | WIDTH | Registered address bus |
| lockup | output | 1 | All-zero address while in sequence mode |

## Verification
An error in any single address bit reaches `addr` on the next edge, because the register is the output. A wrong tap or a wrong shift position does not always show at once. It changes the sequence within a few steps and spoils the return to the seed, so the full 16-bit period run catches defects that only shorten or lengthen the cycle. Errors in the mode multiplexer show on bit 0 one clock after the enabled edge.

// File: rtl/lfsr_addr_pkg.sv
package lfsr_addr_pkg;
  // Tap masks for maximal-length feedback, shift-left Fibonacci form.
  function automatic logic [31:0] default_taps(input int w);
    logic [31:0] m;
    m = '0;
    case (w)
      16: begin m[15] = 1'b1; m[13] = 1'b1; m[12] = 1'b1; m[10] = 1'b1; end
      20: begin m[19] = 1'b1; m[16] = 1'b1; end
      21: begin m[20] = 1'b1; m[18] = 1'b1; end
      22: begin m[21] = 1'b1; m[20] = 1'b1; end
      23: begin m[22] = 1'b1; m[17] = 1'b1; end
      24: begin m[23] = 1'b1; m[22] = 1'b1; m[21] = 1'b1; m[16] = 1'b1; end
      default: begin m[w-1] = 1'b1; m[w-2] = 1'b1; end
    endcase
    return m;
  endfunction
endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
  parameter int WIDTH = 20,
  parameter logic [WIDTH-1:0] TAPS = '1
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb
);
  logic [WIDTH:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign chain[i+1] = chain[i] ^ state[i];
    end else begin : g_off
      assign chain[i+1] = chain[i];
    end
  end
  assign fb = chain[WIDTH];
endmodule

// File: rtl/lfsr_shift_reg.sv
module lfsr_shift_reg #(
  parameter int WIDTH = 20,
  parameter logic [WIDTH-1:0] SEED = WIDTH'(1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             new_bit,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= SEED;
    else if (en) q <= {q[WIDTH-2:0], new_bit};
  end

  assert_reset_seed_R1: assert property (@(posedge clk) rst |=> q == SEED);
  assert_shift_up_R2: assert property (@(posedge clk) disable iff (rst)
    en |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0]));
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));
endmodule

// File: rtl/lfsr_lockup_detect.sv
module lfsr_lockup_detect #(
  parameter int WIDTH = 20
) (
  input  logic [WIDTH-1:0] state,
  input  logic             seq_mode,
  output logic             flag
);
  assign flag = seq_mode && (state == '0);
endmodule

// File: rtl/lfsr_addr_reg.sv
module lfsr_addr_reg #(
  parameter int WIDTH = 20,
  parameter logic [WIDTH-1:0] TAPS = WIDTH'(lfsr_addr_pkg::default_taps(WIDTH))
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             ext_mode,
  input  logic             ser_in,
  output logic [WIDTH-1:0] addr,
  output logic             lockup
);
  localparam logic [WIDTH-1:0] SEED = WIDTH'(1);

  logic fb;
  logic new_bit;

  lfsr_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
    .state(addr), .fb(fb)
  );

  assign new_bit = ext_mode ? ser_in : fb;

  lfsr_shift_reg #(.WIDTH(WIDTH), .SEED(SEED)) u_sr (
    .clk(clk), .rst(rst), .en(step_en), .new_bit(new_bit), .q(addr)
  );

  lfsr_lockup_detect #(.WIDTH(WIDTH)) u_lk (
    .state(addr), .seq_mode(!ext_mode), .flag(lockup)
  );

  assert_tap_feedback_R3: assert property (@(posedge clk) disable iff (rst)
    (step_en && !ext_mode) |=> addr[0] == ^($past(addr) & TAPS));
  assert_serial_insert_R5: assert property (@(posedge clk) disable iff (rst)
    (step_en && ext_mode) |=> addr[0] == $past(ser_in));
  assert_nonzero_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (step_en && !ext_mode && addr != '0) |=> addr != '0);
  assert_zero_stuck_R8: assert property (@(posedge clk) disable iff (rst)
    (step_en && !ext_mode && addr == '0) |=> addr == '0);
endmodule

// File: tb/sim_lfsr_addr_reg.sv
module sim_lfsr_addr_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_en = 1'b0;
  logic ext_mode = 1'b0;
  logic ser_in = 1'b0;
  logic [19:0] addr;
  logic        lockup;
  logic [15:0] addr16;
  logic        lockup16;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lfsr_addr_reg u0 (.clk(clk), .rst(rst), .step_en(step_en), .ext_mode(ext_mode),
    .ser_in(ser_in), .addr(addr), .lockup(lockup));
  lfsr_addr_reg #(.WIDTH(16)) u1 (.clk(clk), .rst(rst), .step_en(step_en),
    .ext_mode(ext_mode), .ser_in(ser_in), .addr(addr16), .lockup(lockup16));

  function automatic logic [19:0] nx20(input logic [19:0] s);
    return {s[18:0], s[19] ^ s[16]};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit r, input bit e, input bit m, input bit b);
    @(negedge clk);
    rst = r; step_en = e; ext_mode = m; ser_in = b;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    check(addr == 20'd1, "R1 seed", addr, 1);
    check(lockup == 1'b0, "R1 lockup low", lockup, 0);
  endtask

  task automatic t_steps();
    logic [19:0] m = addr;
    for (int i = 0; i < 200; i++) begin
      cyc(0, 1, 0, 0);
      m = nx20(m);
    end
    check(addr == m, "R3 tap feedback 200 steps", addr, m);
    check(addr[19:1] != 0 || addr[0], "R2 nonzero shifted", addr, m);
  endtask

  task automatic t_period();
    int early = 0;
    logic [19:0] m = 20'd1;
    int bad = 0;
    t_reset();
    for (int i = 1; i <= 65535; i++) begin
      cyc(0, 1, 0, 0);
      m = nx20(m);
      if (addr != m) bad++;
      if (i < 65535 && addr16 == 16'd1) early++;
    end
    check(addr16 == 16'd1, "R4 return to seed after 2^16-1", addr16, 1);
    check(early == 0, "R4 no early return", early, 0);
    check(bad == 0, "R3 20-bit run matches taps 19,16", bad, 0);
  endtask

  task automatic t_load(input logic [19:0] v);
    for (int i = 19; i >= 0; i--) cyc(0, 1, 1, v[i]);
    check(addr == v, "R5 full serial load", addr, v);
  endtask

  task automatic t_partial();
    logic [19:0] a;
    logic [19:0] e;
    t_load(20'hA5C3E);
    a = addr;
    cyc(0, 1, 1, 1); cyc(0, 1, 1, 0); cyc(0, 1, 1, 1);
    e = {a[16:0], 3'b101};
    check(addr == e, "R6 partial 3-bit load", addr, e);
    cyc(0, 1, 1, 0);
    e = {e[18:0], 1'b0};
    check(addr[19:1] == e[19:1], "R2 bits move up", addr, e);
  endtask

  task automatic t_hold();
    logic [19:0] a = addr;
    cyc(0, 0, 1, 1); cyc(0, 0, 0, 0); cyc(0, 0, 1, 0); cyc(0, 0, 0, 1);
    check(addr == a, "R7 hold with enable low", addr, a);
  endtask

  task automatic t_lockup();
    t_load(20'h0);
    check(lockup == 1'b0, "R8 no flag in external mode", lockup, 0);
    cyc(0, 0, 0, 0);
    check(lockup == 1'b1, "R8 flag on zero in sequence mode", lockup, 1);
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0);
    check(addr == 20'h0 && lockup, "R8 zero stays locked", addr, 0);
    t_load(20'h00001);
    cyc(0, 0, 0, 0);
    check(lockup == 1'b0, "R8 flag clears on nonzero", lockup, 0);
    t_reset();
  endtask

  initial begin
    t_reset();
    t_steps();
    t_hold();
    t_load(20'hFFFFF);
    t_load(20'h80001);
    t_partial();
    t_hold();
    t_lockup();
    t_period();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule